// File: doc/BRIEF.md
# Multi-Cycle 16-bit Processor Core

This block is a small 16-bit processor core that runs programs held in an external single-port word memory. The core steps each instruction through a short state sequence: it fetches one instruction word, fetches a second word only when the opcode carries a 16-bit immediate, executes, and for loads spends one extra cycle writing the returned word back. Each cycle makes at most one memory access. A read issued in one cycle returns its data on the read-data port in the next cycle.

The register file holds fifteen general 16-bit registers plus a register 0 that always reads as zero. The instruction set covers register-register and register-immediate arithmetic, logic and signed compares. It also has constant and variable shifts, loads and stores with an optional immediate offset, compare-and-branch with a link register, and register jumps with a link register. An opcode in the memory or indexed-memory group with an undefined subfunction stops the core. The core then raises a sticky status output and makes no further memory access. Test programs use this stop as their end marker.

Top module: `cpu16_core`

## Requirements
- R1: On a synchronous active-high reset, the PC, all registers and the sequencer clear. In the first cycle after reset the core reads address 0x0000, and the illegal output is low.
- R2: Register specifier 0 reads as 0x0000 as a source, and any result aimed at register 0 is discarded.
- R3: Instruction fields are op=[15:12], d=[11:8], a=[7:4], b=[3:0]. Opcodes 0000/0001/0010/0011/0100 write Reg[a] plus/and/or/xor/minus Reg[b] into Reg[d]. Opcodes 0101/0110 write 1 into Reg[d] when Reg[a] is greater than, or greater than or equal to, Reg[b] as signed numbers, and write 0 otherwise.
- R4: Opcodes 1001/1010/1011 shift Reg[a] left, logically right or arithmetically right by the 4-bit constant in [3:0]. Opcode 1000 shifts Reg[a] left by signed Reg[b] when it is non-negative, and arithmetically right by its magnitude when it is negative. A shift of 16 or more places gives 0, or all sign bits for a right shift.
- R5: Opcode 1110 applies the operation selected by bits [3:0] to Reg[a] and the following immediate word: 0000 add, 0001 and, 0010 or, 0011 xor, 0100 subtract, 0101 signed greater, 0110 signed greater-or-equal.
- R6: Opcode 0111 with subfunction 1110 stores Reg[d] at address Reg[a], and with 1111 loads the word at Reg[a] into Reg[d]. Opcode 1111 does the same at address Reg[a] plus the immediate word.
- R7: Opcodes 1100 (equal) and 1101 (not equal) compare Reg[a] with Reg[b]. When the branch is taken, PC+2 goes into Reg[d] and the PC takes the immediate word. When it is not taken, execution continues at PC+2 and Reg[d] is unchanged.
- R8: Opcode 0111 with subfunction 0000 jumps to Reg[a] and writes PC+1 into Reg[d]. Opcode 1111 with subfunction 0000 jumps to Reg[a] plus the immediate word and writes PC+2 into Reg[d]. The target is formed from Reg[a] as it was before the link write.
- R9: A second instruction word is read only for opcodes 1100 to 1111, so an instruction costs one read, or two reads for those opcodes, plus one data access for a load or store. Read and write are never asserted together.
- R10: Opcode 0111 or 1111 with a subfunction other than 0000, 1110 or 1111 sets the illegal output. The output stays set until reset, and the core makes no further memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 16 | Word address of the current access |
| mem_wdata | output | 16 | Data to write |
| mem_we | output | 1 | Write strobe for this cycle |
| mem_re | output | 1 | Read strobe; data returns next cycle |
| mem_rdata | input | 16 | Read data for the previous cycle's read |
| illegal_halt | output | 1 | Sticky: an undefined subfunction stopped the core |

## Verification
Some properties hold on every cycle and are checked by assertions at the memory port. These are: the fetch from address zero right after reset, the exclusion of read and write in the same cycle, the fetch that follows every store, and the sticky, silent stop after an illegal instruction. The arithmetic results, shift corner cases, link values, branch targets and the exact read count per instruction length can only be seen by running programs. The bench writes each program into its memory model and reads the stored results back from that memory.

// File: rtl/cpu16_pkg.sv
`timescale 1ns/1ps
package cpu16_pkg;
    localparam int XLEN = 16;
    localparam int NREG = 16;
    localparam int RIDX = $clog2(NREG);

    typedef logic [XLEN-1:0] word_t;

    localparam logic [3:0] OP_SRV  = 4'b1000;
    localparam logic [3:0] OP_SHL  = 4'b1001;
    localparam logic [3:0] OP_SHR  = 4'b1010;
    localparam logic [3:0] OP_SRA  = 4'b1011;
    localparam logic [3:0] OP_MEM  = 4'b0111;
    localparam logic [3:0] OP_BEQ  = 4'b1100;
    localparam logic [3:0] OP_BNE  = 4'b1101;
    localparam logic [3:0] OP_ALUI = 4'b1110;
    localparam logic [3:0] OP_MEMX = 4'b1111;
    localparam logic [3:0] SUB_JMP = 4'b0000;
    localparam logic [3:0] SUB_ST  = 4'b1110;
    localparam logic [3:0] SUB_LD  = 4'b1111;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SGT, ALU_SGE, ALU_AND, ALU_OR, ALU_XOR,
        ALU_SHL, ALU_SHR, ALU_SRA, ALU_SRV
    } alu_op_e;

    typedef enum logic [2:0] {
        K_ALU, K_LOAD, K_STORE, K_JUMP, K_BEQ, K_BNE, K_NOP, K_ILL
    } kind_e;

    typedef enum logic [1:0] { OPB_REG, OPB_IMM, OPB_SH4 } opb_e;

    typedef enum logic [2:0] {
        S_FETCH, S_DECODE, S_IMM, S_EXEC, S_WB, S_HALT
    } state_e;

    typedef struct packed {
        kind_e           kind;
        alu_op_e         alu;
        opb_e            opb;
        logic            two_word;
        logic [RIDX-1:0] rd;
        logic [RIDX-1:0] ra;
        logic [RIDX-1:0] rb;
    } dec_t;

    function automatic logic has_imm_word(input logic [3:0] op);
        return (op & 4'b1100) == 4'b1100;
    endfunction

    // Shared selector code for register-register opcodes and immediate subfunctions
    function automatic alu_op_e sel_to_alu(input logic [3:0] sel);
        case (sel)
            4'd0:    return ALU_ADD;
            4'd1:    return ALU_AND;
            4'd2:    return ALU_OR;
            4'd3:    return ALU_XOR;
            4'd4:    return ALU_SUB;
            4'd5:    return ALU_SGT;
            default: return ALU_SGE;
        endcase
    endfunction
endpackage

// File: rtl/cpu16_regfile.sv
`timescale 1ns/1ps
module cpu16_regfile
    import cpu16_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = XLEN,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [IW-1:0] ra1,
    input  logic [IW-1:0] ra2,
    input  logic [IW-1:0] ra3,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3
);
    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (we && (wa == IW'(g)) && (g != 0))
                regs[g] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs[ra3];
endmodule

// File: rtl/cpu16_decode.sv
`timescale 1ns/1ps
module cpu16_decode
    import cpu16_pkg::*;
(
    input  word_t ir,
    output dec_t  dec
);
    logic [3:0] op, fn;
    assign op = ir[15:12];
    assign fn = ir[3:0];

    always_comb begin
        dec          = '0;
        dec.rd       = ir[11:8];
        dec.ra       = ir[7:4];
        dec.rb       = ir[3:0];
        dec.two_word = has_imm_word(op);
        dec.kind     = K_ALU;
        dec.opb      = OPB_REG;
        dec.alu      = ALU_ADD;
        case (op)
            OP_SRV: dec.alu = ALU_SRV;
            OP_SHL: begin dec.alu = ALU_SHL; dec.opb = OPB_SH4; end
            OP_SHR: begin dec.alu = ALU_SHR; dec.opb = OPB_SH4; end
            OP_SRA: begin dec.alu = ALU_SRA; dec.opb = OPB_SH4; end
            OP_BEQ: dec.kind = K_BEQ;
            OP_BNE: dec.kind = K_BNE;
            OP_MEM, OP_MEMX: begin
                case (fn)
                    SUB_ST:  dec.kind = K_STORE;
                    SUB_LD:  dec.kind = K_LOAD;
                    SUB_JMP: dec.kind = K_JUMP;
                    default: dec.kind = K_ILL;
                endcase
            end
            OP_ALUI: begin
                dec.opb = OPB_IMM;
                dec.alu = sel_to_alu(fn);
                if (fn > 4'd6) dec.kind = K_NOP;
            end
            default: dec.alu = sel_to_alu(op);
        endcase
    end
endmodule

// File: rtl/cpu16_alu.sv
`timescale 1ns/1ps
module cpu16_alu
    import cpu16_pkg::*;
(
    input  alu_op_e op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);
    word_t neg_b;
    assign neg_b = -b;

    always_comb begin
        case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_XOR: y = a ^ b;
            ALU_SGT: y = {{(XLEN-1){1'b0}}, ($signed(a) > $signed(b))};
            ALU_SGE: y = {{(XLEN-1){1'b0}}, ($signed(a) >= $signed(b))};
            ALU_SHL: y = a << b;
            ALU_SHR: y = a >> b;
            ALU_SRA: y = word_t'($signed(a) >>> b);
            ALU_SRV: y = b[XLEN-1] ? word_t'($signed(a) >>> neg_b) : (a << b);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/cpu16_core.sv
`timescale 1ns/1ps
module cpu16_core
    import cpu16_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    input  logic [15:0] mem_rdata,
    output logic        illegal_halt
);
    state_e state_q;
    word_t  pc_q, ir_q, imm_q;
    logic   illegal_q;

    dec_t   dec;
    word_t  a_val, b_val, d_val, opb_val, alu_y, next_seq, eff_addr;
    logic   rf_we, taken;
    word_t  rf_wd;

    cpu16_decode u_dec (.ir(ir_q), .dec(dec));

    cpu16_regfile #(.N(NREG), .W(XLEN)) u_rf (
        .clk(clk), .rst(rst), .we(rf_we), .wa(dec.rd), .wd(rf_wd),
        .ra1(dec.ra), .ra2(dec.rb), .ra3(dec.rd),
        .rd1(a_val), .rd2(b_val), .rd3(d_val)
    );

    always_comb begin
        case (dec.opb)
            OPB_IMM: opb_val = imm_q;
            OPB_SH4: opb_val = {{(XLEN-4){1'b0}}, ir_q[3:0]};
            default: opb_val = b_val;
        endcase
    end

    cpu16_alu u_alu (.op(dec.alu), .a(a_val), .b(opb_val), .y(alu_y));

    assign next_seq = pc_q + (dec.two_word ? word_t'(2) : word_t'(1));
    assign eff_addr = a_val + (dec.two_word ? imm_q : '0);
    assign taken    = (dec.kind == K_BEQ) ? (a_val == b_val) :
                      (dec.kind == K_BNE) ? (a_val != b_val) : 1'b0;

    always_comb begin
        mem_addr  = pc_q;
        mem_wdata = d_val;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        rf_we     = 1'b0;
        rf_wd     = alu_y;
        case (state_q)
            S_FETCH: mem_re = 1'b1;
            S_DECODE: begin
                if (has_imm_word(mem_rdata[15:12])) begin
                    mem_re   = 1'b1;
                    mem_addr = pc_q + word_t'(1);
                end
            end
            S_EXEC: begin
                case (dec.kind)
                    K_ALU:   rf_we = 1'b1;
                    K_STORE: begin mem_we = 1'b1; mem_addr = eff_addr; end
                    K_LOAD:  begin mem_re = 1'b1; mem_addr = eff_addr; end
                    K_JUMP:  begin rf_we = 1'b1; rf_wd = next_seq; end
                    K_BEQ, K_BNE: begin rf_we = taken; rf_wd = next_seq; end
                    default: ;
                endcase
            end
            S_WB: begin rf_we = 1'b1; rf_wd = mem_rdata; end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= S_FETCH;
            pc_q      <= '0;
            ir_q      <= '0;
            imm_q     <= '0;
            illegal_q <= 1'b0;
        end else begin
            case (state_q)
                S_FETCH: state_q <= S_DECODE;
                S_DECODE: begin
                    ir_q    <= mem_rdata;
                    state_q <= has_imm_word(mem_rdata[15:12]) ? S_IMM : S_EXEC;
                end
                S_IMM: begin
                    imm_q   <= mem_rdata;
                    state_q <= S_EXEC;
                end
                S_EXEC: begin
                    state_q <= S_FETCH;
                    case (dec.kind)
                        K_LOAD:  state_q <= S_WB;
                        K_ILL: begin
                            illegal_q <= 1'b1;
                            state_q   <= S_HALT;
                        end
                        K_JUMP:  pc_q <= eff_addr;
                        K_BEQ, K_BNE: pc_q <= taken ? imm_q : next_seq;
                        default: pc_q <= next_seq;
                    endcase
                end
                S_WB: begin
                    pc_q    <= next_seq;
                    state_q <= S_FETCH;
                end
                default: state_q <= S_HALT;
            endcase
        end
    end

    assign illegal_halt = illegal_q;
endmodule

// File: rtl/cpu16_core_chk.sv
`timescale 1ns/1ps
module cpu16_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        mem_re,
    input logic        illegal_halt
);
    a_r1_first_fetch_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_re && !mem_we && mem_addr == 16'h0000 && !illegal_halt));

    a_r9_one_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_re && mem_we));

    a_r6_store_then_fetch: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (mem_re && !mem_we));

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        illegal_halt |=> illegal_halt);

    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal_halt |-> (!mem_re && !mem_we));
endmodule

bind cpu16_core cpu16_core_chk u_chk (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_re(mem_re), .illegal_halt(illegal_halt)
);

// File: tb/cpu16_core_test.sv
`timescale 1ns/1ps
module cpu16_core_test;
    localparam int MEMW = 4096;
    localparam logic [15:0] RES = 16'h0F00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we, mem_re, illegal_halt;

    always #2.5 clk = ~clk;

    cpu16_core uut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .illegal_halt(illegal_halt)
    );

    logic [15:0] mem [0:MEMW-1];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
    end

    int n_rd = 0, n_wr = 0, n_both = 0, cyc = 0;
    int checks = 0, fails = 0, wp = 0;

    always @(posedge clk) begin
        cyc++;
        if (!rst) begin
            if (mem_re) n_rd++;
            if (mem_we) n_wr++;
            if (mem_re && mem_we) n_both++;
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        wait (cyc >= 150000);
        checks++; fails++;
        $display("FAIL watchdog: got %0d cycles expected completion", cyc);
        summary();
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [3:0] d,
                                        input logic [3:0] a, input logic [3:0] b);
        return {op, d, a, b};
    endfunction

    task automatic emit(input logic [15:0] w);
        mem[wp[11:0]] = w;
        wp++;
    endtask
    task automatic li(input logic [3:0] d, input logic [15:0] v);
        emit(enc(4'hE, d, 4'h0, 4'h0)); emit(v);
    endtask
    task automatic sx(input logic [3:0] d, input logic [15:0] addr);
        emit(enc(4'hF, d, 4'h0, 4'hE)); emit(addr);
    endtask
    task automatic stop_word();
        emit(16'h7001);
    endtask
    task automatic new_prog();
        for (int i = 0; i < MEMW; i++) mem[i] = 16'h0000;
        wp = 0;
    endtask

    task automatic run(input bit check_reset);
        int t;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        n_rd = 0; n_wr = 0;
        #0.5;
        if (check_reset) begin
            chk("R1 first read strobe", {15'b0, mem_re}, 16'h0001);
            chk("R1 first address", mem_addr, 16'h0000);
            chk("R1 illegal low", {15'b0, illegal_halt}, 16'h0000);
        end
        t = 0;
        while (!illegal_halt && t < 3000) begin
            @(negedge clk);
            t++;
        end
        if (!illegal_halt) begin
            checks++; fails++;
            $display("FAIL run: got no stop expected stop word");
        end
    endtask

    function automatic logic [15:0] ref_alu(input logic [3:0] sel, input logic [15:0] a,
                                            input logic [15:0] b);
        int n;
        case (sel)
            4'h0: return a + b;
            4'h1: return a & b;
            4'h2: return a | b;
            4'h3: return a ^ b;
            4'h4: return a - b;
            4'h5: return ($signed(a) > $signed(b)) ? 16'd1 : 16'd0;
            4'h6: return ($signed(a) >= $signed(b)) ? 16'd1 : 16'd0;
            4'h9: return a << b[3:0];
            4'hA: return a >> b[3:0];
            4'hB: return 16'($signed(a) >>> b[3:0]);
            4'h8: begin
                if (b[15]) begin
                    n = 65536 - int'(b);
                    if (n >= 16) return a[15] ? 16'hFFFF : 16'h0000;
                    return 16'($signed(a) >>> n);
                end
                n = int'(b);
                if (n >= 16) return 16'h0000;
                return a << n;
            end
            default: return 16'h0000;
        endcase
    endfunction

    task automatic rr_case(input logic [3:0] sel, input logic [15:0] x, input logic [15:0] y,
                           input string req);
        bit sh;
        sh = (sel >= 4'h9);
        new_prog();
        li(4'd1, x); li(4'd2, y);
        if (sh) emit(enc(sel, 4'd3, 4'd1, y[3:0]));
        else    emit(enc(sel, 4'd3, 4'd1, 4'd2));
        sx(4'd3, RES);
        stop_word();
        mem[RES[11:0]] = 16'hDEAD;
        run(1'b0);
        chk(req, mem[RES[11:0]], ref_alu(sel, x, y));
    endtask

    task automatic imm_case(input logic [3:0] sel, input logic [15:0] x, input logic [15:0] y);
        new_prog();
        li(4'd1, x);
        emit(enc(4'hE, 4'd4, 4'd1, sel)); emit(y);
        sx(4'd4, RES);
        stop_word();
        mem[RES[11:0]] = 16'hDEAD;
        run(1'b0);
        chk("R5 immediate alu", mem[RES[11:0]], ref_alu(sel, x, y));
    endtask

    initial begin
        logic [3:0] ops [11];
        logic [15:0] x, y;
        int pre;
        ops = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h8, 4'h9, 4'hA, 4'hB};
        void'($urandom(32'd20240611));

        // R1: reset state, then registers cleared across a second reset
        new_prog(); li(4'd5, 16'h4321); stop_word();
        run(1'b1);
        new_prog(); sx(4'd5, RES); stop_word();
        mem[RES[11:0]] = 16'hFFFF;
        run(1'b1);
        chk("R1 register cleared by reset", mem[RES[11:0]], 16'h0000);

        // R2: register zero
        new_prog();
        li(4'd5, 16'h0077); li(4'd0, 16'h1234);
        emit(enc(4'h0, 4'd5, 4'd0, 4'd0));
        sx(4'd0, RES); sx(4'd5, RES + 16'd1); stop_word();
        mem[RES[11:0]] = 16'hAAAA; mem[RES[11:0] + 12'd1] = 16'hAAAA;
        run(1'b0);
        chk("R2 write to reg0 discarded", mem[RES[11:0]], 16'h0000);
        chk("R2 reg0 reads zero", mem[RES[11:0] + 12'd1], 16'h0000);

        // R4: directed variable and constant shift corners
        rr_case(4'h8, 16'h8001, 16'hFFF0, "R4 srv -16");
        rr_case(4'h8, 16'h8001, 16'hFFFF, "R4 srv -1");
        rr_case(4'h8, 16'h0003, 16'h0010, "R4 srv +16");
        rr_case(4'h8, 16'h1234, 16'h0000, "R4 srv 0");
        rr_case(4'h8, 16'h8234, 16'h8000, "R4 srv most negative");
        rr_case(4'hB, 16'h8000, 16'h000F, "R4 sra 15");
        rr_case(4'h9, 16'h00F1, 16'h0004, "R4 shl 4");
        // R3: signed compare corners
        rr_case(4'h5, 16'h8000, 16'h7FFF, "R3 sgt signed");
        rr_case(4'h6, 16'h1234, 16'h1234, "R3 sge equal");
        rr_case(4'h5, 16'h1234, 16'h1234, "R3 sgt equal");

        // R3/R4/R5: random operations
        for (int i = 0; i < 50; i++) begin
            logic [3:0] sel;
            sel = ops[$urandom % 11];
            x = 16'($urandom);
            y = 16'($urandom);
            if (sel == 4'h8) y = 16'(($urandom % 40) - 20);
            if ((sel == 4'h5 || sel == 4'h6) && ($urandom % 4 == 0)) y = x;
            rr_case(sel, x, y, (sel >= 4'h8) ? "R4 random shift" : "R3 random op");
            if (sel <= 4'h6) imm_case(sel, 16'($urandom), 16'($urandom));
        end

        // R6: loads and stores, plain and indexed
        new_prog();
        li(4'd1, 16'h0200); li(4'd2, 16'h5A5A);
        emit(enc(4'h7, 4'd2, 4'd1, 4'hE));
        emit(enc(4'h7, 4'd3, 4'd1, 4'hF));
        emit(enc(4'hF, 4'd4, 4'd1, 4'hF)); emit(16'd5);
        emit(enc(4'hF, 4'd4, 4'd1, 4'hE)); emit(16'd6);
        sx(4'd3, RES); stop_word();
        mem[12'h205] = 16'hC3C3;
        run(1'b0);
        chk("R6 store", mem[12'h200], 16'h5A5A);
        chk("R6 indexed load then store", mem[12'h206], 16'hC3C3);
        chk("R6 load", mem[RES[11:0]], 16'h5A5A);

        // R7: branches
        new_prog();
        li(4'd1, 16'd5); li(4'd2, 16'd5); li(4'd8, 16'h0055);
        emit(enc(4'hC, 4'd6, 4'd1, 4'd2)); emit(16'h0010);
        li(4'd7, 16'h0BAD);
        wp = 16'h10;
        emit(enc(4'hD, 4'd8, 4'd1, 4'd2)); emit(16'h0040);
        emit(enc(4'hC, 4'd9, 4'd1, 4'd0)); emit(16'h0040);
        emit(enc(4'hD, 4'd10, 4'd1, 4'd0)); emit(16'h0030);
        stop_word();
        wp = 16'h30;
        sx(4'd6, RES); sx(4'd7, RES + 16'd1); sx(4'd8, RES + 16'd2);
        sx(4'd10, RES + 16'd3); sx(4'd9, RES + 16'd4); stop_word();
        mem[RES[11:0] + 12'd4] = 16'hFFFF;
        run(1'b0);
        chk("R7 beq taken link", mem[RES[11:0]], 16'h0008);
        chk("R7 skipped instruction", mem[RES[11:0] + 12'd1], 16'h0000);
        chk("R7 bne not taken keeps link", mem[RES[11:0] + 12'd2], 16'h0055);
        chk("R7 bne taken link", mem[RES[11:0] + 12'd3], 16'h0016);
        chk("R7 beq not taken no link", mem[RES[11:0] + 12'd4], 16'h0000);

        // R8: register jumps
        new_prog();
        li(4'd1, 16'h0020);
        emit(enc(4'h7, 4'd5, 4'd1, 4'h0));
        stop_word();
        wp = 16'h20;
        emit(enc(4'hF, 4'd6, 4'd1, 4'h0)); emit(16'h0010);
        stop_word();
        wp = 16'h30;
        li(4'd2, 16'h0040);
        emit(enc(4'h7, 4'd2, 4'd2, 4'h0));
        stop_word();
        wp = 16'h40;
        sx(4'd5, RES); sx(4'd6, RES + 16'd1); sx(4'd2, RES + 16'd2); stop_word();
        run(1'b0);
        chk("R8 jr link", mem[RES[11:0]], 16'h0003);
        chk("R8 indexed jump link", mem[RES[11:0] + 12'd1], 16'h0022);
        chk("R8 jr same register", mem[RES[11:0] + 12'd2], 16'h0033);

        // R9: reads per instruction length
        new_prog();
        emit(enc(4'h0, 4'd1, 4'd0, 4'd0)); emit(enc(4'h1, 4'd1, 4'd0, 4'd0));
        emit(enc(4'h3, 4'd1, 4'd0, 4'd0)); stop_word();
        run(1'b0);
        chk("R9 one-word reads", 16'(n_rd), 16'd4);
        chk("R9 no writes", 16'(n_wr), 16'd0);
        new_prog();
        li(4'd1, 16'd5); li(4'd2, 16'd6); stop_word();
        run(1'b0);
        chk("R9 two-word reads", 16'(n_rd), 16'd5);

        // R10: illegal subfunctions
        new_prog();
        li(4'd1, 16'd9);
        emit(enc(4'h7, 4'd1, 4'd0, 4'h5));
        sx(4'd1, RES); stop_word();
        mem[RES[11:0]] = 16'h1111;
        run(1'b0);
        pre = n_rd + n_wr;
        repeat (10) @(negedge clk);
        chk("R10 sticky", {15'b0, illegal_halt}, 16'h0001);
        chk("R10 no access after stop", 16'(n_rd + n_wr - pre), 16'd0);
        chk("R10 later store not done", mem[RES[11:0]], 16'h1111);
        new_prog();
        emit(enc(4'hF, 4'd1, 4'd0, 4'h3)); emit(16'h0000);
        run(1'b0);
        chk("R10 indexed group illegal", {15'b0, illegal_halt}, 16'h0001);
        chk("R10 two-word illegal reads", 16'(n_rd), 16'd2);

        chk("R9 never read and write together", 16'(n_both), 16'd0);
        summary();
    end
endmodule